// File: doc/BRIEF.md
# Reset Source Sequencing Controller

This block orders the steps of a chip reset for three request sources. The first is a boundary-scan reset request that arrives as a plain input together with a level hint for the external reset pin. The second is a software system reset bit. The third is a software external reset bit. For each source the block drives an internal core reset and an external reset output over a fixed sequence of states. It runs a cycle counter whose length is a parameter. It latches the wake and PLL reference mode inputs when the core reset starts, and it samples the wake and boot configuration inputs at a defined point near the end of the sequence.

A small register port exposes two locations. The control register at address 0 holds the system reset request in bit 0 and the external reset request in bit 1. The status register at address 1 holds two reset-source flags and the sampled configuration. Each source leaves its own mark on the status register:

- An external-only reset sets just its own flag.
- A system reset sets its own flag and clears the other.
- A boundary-scan reset refreshes only the configuration fields.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After the synchronous reset, `core_rst_o`, `ext_rst_o`, `busy_o`, `wake_apply_o` and `pll_mode_o` are 0, and both registers read 0.
- R2: Writing address 0 with bit 0 set while idle starts a system reset. Both `core_rst_o` and `ext_rst_o` are high for exactly CNT_CYCLES+6 cycles: 1 assert cycle, CNT_CYCLES count cycles, 1 sample cycle and 4 hold cycles. At the end, status bit 0 is set and status bit 1 is cleared.
- R3: The status register holds the sampled wake input in bit 4 and the boot input in bits 6:5. For a system reset these are captured at the end of the sample cycle, before the 4 hold cycles, so input changes during the hold do not reach the status register.
- R4: Writing address 0 with bit 1 set (and bit 0 clear) while idle starts an external-only reset. `ext_rst_o` is high for exactly CNT_CYCLES cycles, `core_rst_o` stays low, and the configuration fields are unchanged. Status bit 1 is set and every other status bit is left as it was.
- R5: A boundary-scan request (`scan_rst_req` high) holds `core_rst_o` high while the request lasts, then for CNT_CYCLES further cycles, then for 1 sample cycle. While the request is high, `ext_rst_o` equals `scan_ext_lvl`; after that it is low. The configuration fields are refreshed and status bits 1:0 are unchanged.
- R6: On the clock edge that starts the core reset of a system or boundary-scan sequence, `wake_apply_o` and `pll_mode_o` take the values of `wake_cfg_in` and `pll_mode_in`. An external-only reset leaves them unchanged.
- R7: Control bit 0 reads 1 only while a system reset sequence is in progress, and control bit 1 reads 1 only while an external-only sequence is in progress. Both read 0 when idle.
- R8: A control write while a sequence is active is ignored. A boundary-scan request preempts any active system or external-only sequence and restarts the count.
- R9: Writing address 1 clears each of status bits 1:0 whose write bit is 1. The configuration fields cannot be written.
- R10: `busy_o` is high from the first cycle of a sequence through one release cycle in which both reset outputs are already low.
- R11: A control write with both bits set while idle starts a system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_rst_req | input | 1 | Boundary-scan reset request |
| scan_ext_lvl | input | 1 | Level for the external reset output while the scan request is high |
| wake_cfg_in | input | 1 | Wake configuration input |
| pll_mode_in | input | 1 | PLL reference mode input |
| boot_cfg_in | input | 2 | Boot configuration input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 is control, 1 is status |
| reg_wbits | input | 2 | Write data for bits 1:0 |
| reg_rdata | output | 8 | Read data of the selected register |
| core_rst_o | output | 1 | Internal reset, active high |
| ext_rst_o | output | 1 | External reset output, active high |
| wake_apply_o | output | 1 | Wake value latched when the core reset starts |
| pll_mode_o | output | 1 | PLL mode value latched when the core reset starts |
| busy_o | output | 1 | A sequence is in progress |

## Verification
A wrong state or a miscounted counter changes the number of cycles for which `core_rst_o` or `ext_rst_o` is high. That difference is visible by the end of the sequence, at most CNT_CYCLES+7 cycles after the start. A source mix-up shows up in the status flags or in the control readback as soon as the sequence ends. A sample taken at the wrong point shows up as configuration fields that hold values driven during the hold window. A failed preemption shows up as an extra or a missing assert cycle within a few cycles of the scan request.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASSERT,
        ST_COUNT,
        ST_SAMPLE,
        ST_HOLD4,
        ST_RELEASE
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_SCAN,
        SRC_SYS,
        SRC_EXT
    } src_e;

    localparam int  HOLD_CYCLES = 4;
    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_STAT  = 1'b1;

    typedef struct packed {
        logic [1:0] boot;
        logic       wake;
    } cfg_t;

    typedef struct packed {
        logic flag_ext;
        logic flag_sys;
    } flags_t;

    typedef struct packed {
        logic latch;
        logic sample;
        logic sys_done;
        logic ext_done;
    } seq_evt_t;

    // status layout: [6:5] boot, [4] wake, [1] ext flag, [0] sys flag
    function automatic logic [7:0] pack_status(flags_t f, cfg_t c);
        return {1'b0, c.boot, c.wake, 2'b00, f.flag_ext, f.flag_sys};
    endfunction

endpackage

// File: rtl/rsc_fsm.sv
module rsc_fsm
    import rsc_pkg::*;
#(
    parameter int CNT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scan_req,
    input  logic       start_sys,
    input  logic       start_ext,
    output seq_state_e state,
    output src_e       src,
    output seq_evt_t   evt
);
    localparam int CNT_W = $clog2(CNT_CYCLES + HOLD_CYCLES) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CNT_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

    seq_state_e       nxt_state;
    src_e             nxt_src;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic             scan_take;

    always_comb begin
        nxt_state = state;
        nxt_src   = src;
        nxt_cnt   = cnt + 1'b1;
        evt       = '0;
        scan_take = scan_req && !(state == ST_ASSERT && src == SRC_SCAN);
        if (scan_take) begin
            nxt_state = ST_ASSERT;
            nxt_src   = SRC_SCAN;
            nxt_cnt   = '0;
            evt.latch = 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    nxt_cnt = '0;
                    if (start_sys) begin
                        nxt_state = ST_ASSERT;
                        nxt_src   = SRC_SYS;
                        evt.latch = 1'b1;
                    end else if (start_ext) begin
                        nxt_state = ST_COUNT;
                        nxt_src   = SRC_EXT;
                    end
                end
                ST_ASSERT: begin
                    nxt_cnt = '0;
                    if (src != SRC_SCAN || !scan_req) nxt_state = ST_COUNT;
                end
                ST_COUNT: begin
                    if (cnt == CNT_LAST) begin
                        nxt_cnt = '0;
                        if (src == SRC_EXT) begin
                            nxt_state    = ST_RELEASE;
                            evt.ext_done = 1'b1;
                        end else begin
                            nxt_state = ST_SAMPLE;
                        end
                    end
                end
                ST_SAMPLE: begin
                    nxt_cnt    = '0;
                    evt.sample = 1'b1;
                    nxt_state  = (src == SRC_SYS) ? ST_HOLD4 : ST_RELEASE;
                end
                ST_HOLD4: begin
                    if (cnt == HOLD_LAST) begin
                        nxt_cnt      = '0;
                        nxt_state    = ST_RELEASE;
                        evt.sys_done = 1'b1;
                    end
                end
                default: begin
                    nxt_cnt   = '0;
                    nxt_state = ST_IDLE;
                    nxt_src   = SRC_NONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            src   <= SRC_NONE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            src   <= nxt_src;
            cnt   <= nxt_cnt;
        end
    end

endmodule

// File: rtl/rsc_regs.sv
module rsc_regs
    import rsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_evt_t   evt,
    input  logic       wake_in,
    input  logic       pll_in,
    input  logic [1:0] boot_in,
    input  logic       clr_wr,
    input  logic [1:0] clr_mask,
    output flags_t     flags,
    output cfg_t       cfg,
    output logic       wake_apply,
    output logic       pll_mode
);
    flags_t nxt_flags;

    always_comb begin
        nxt_flags = flags;
        if (clr_wr) nxt_flags = flags_t'(flags & ~clr_mask);
        if (evt.sys_done) begin
            nxt_flags.flag_sys = 1'b1;
            nxt_flags.flag_ext = 1'b0;
        end
        if (evt.ext_done) nxt_flags.flag_ext = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            cfg        <= '0;
            wake_apply <= 1'b0;
            pll_mode   <= 1'b0;
        end else begin
            flags <= nxt_flags;
            if (evt.latch) begin
                wake_apply <= wake_in;
                pll_mode   <= pll_in;
            end
            if (evt.sample) cfg <= '{boot: boot_in, wake: wake_in};
        end
    end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int CNT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scan_rst_req,
    input  logic       scan_ext_lvl,
    input  logic       wake_cfg_in,
    input  logic       pll_mode_in,
    input  logic [1:0] boot_cfg_in,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [1:0] reg_wbits,
    output logic [7:0] reg_rdata,
    output logic       core_rst_o,
    output logic       ext_rst_o,
    output logic       wake_apply_o,
    output logic       pll_mode_o,
    output logic       busy_o
);
    seq_state_e state;
    src_e       src;
    seq_evt_t   evt;
    flags_t     flags;
    cfg_t       cfg;
    logic       ctrl_wr, in_seq;
    logic [7:0] ctrl_rd, stat_rd;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    rsc_fsm #(.CNT_CYCLES(CNT_CYCLES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .scan_req  (scan_rst_req),
        .start_sys (ctrl_wr && reg_wbits[0]),
        .start_ext (ctrl_wr && reg_wbits[1]),
        .state     (state),
        .src       (src),
        .evt       (evt)
    );

    rsc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .wake_in    (wake_cfg_in),
        .pll_in     (pll_mode_in),
        .boot_in    (boot_cfg_in),
        .clr_wr     (reg_wr && (reg_addr == ADDR_STAT)),
        .clr_mask   (reg_wbits),
        .flags      (flags),
        .cfg        (cfg),
        .wake_apply (wake_apply_o),
        .pll_mode   (pll_mode_o)
    );

    assign in_seq  = (state == ST_ASSERT) || (state == ST_COUNT) ||
                     (state == ST_SAMPLE) || (state == ST_HOLD4);
    assign busy_o  = (state != ST_IDLE);

    assign core_rst_o = in_seq && (src != SRC_EXT);
    assign ext_rst_o  = (state == ST_ASSERT && src == SRC_SCAN) ? scan_ext_lvl
                                                                : (in_seq && src != SRC_SCAN);

    assign ctrl_rd   = {6'b0, busy_o && (src == SRC_EXT), busy_o && (src == SRC_SYS)};
    assign stat_rd   = pack_status(flags, cfg);
    assign reg_rdata = (reg_addr == ADDR_STAT) ? stat_rd : ctrl_rd;

endmodule

// File: rtl/rsc_chk.sv
module rsc_chk (
    input logic       clk,
    input logic       rst,
    input logic       core_rst_o,
    input logic       ext_rst_o,
    input logic       busy_o,
    input logic       wake_cfg_in,
    input logic       pll_mode_in,
    input logic       wake_apply_o,
    input logic       pll_mode_o,
    input logic [7:0] ctrl_rd,
    input logic [7:0] stat_rd
);
    // R6
    latch_on_assert_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst_o) |-> (wake_apply_o == $past(wake_cfg_in) && pll_mode_o == $past(pll_mode_in)));

    // R4
    ext_only_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd[1] |-> !core_rst_o);

    // R2
    sys_clears_ext_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_rd[0]) |-> !stat_rd[1]);

    // R3
    cfg_only_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(stat_rd[6:4]) |-> $past(busy_o));

    // R10
    busy_tail_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(!core_rst_o && !ext_rst_o));

    // R7
    ctrl_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (ctrl_rd == 8'h00));

endmodule

bind rst_seq_ctrl rsc_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .core_rst_o   (core_rst_o),
    .ext_rst_o    (ext_rst_o),
    .busy_o       (busy_o),
    .wake_cfg_in  (wake_cfg_in),
    .pll_mode_in  (pll_mode_in),
    .wake_apply_o (wake_apply_o),
    .pll_mode_o   (pll_mode_o),
    .ctrl_rd      (ctrl_rd),
    .stat_rd      (stat_rd)
);

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rst_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_rst_req = 1'b0, scan_ext_lvl = 1'b0;
    logic       wake_cfg_in = 1'b0, pll_mode_in = 1'b0;
    logic [1:0] boot_cfg_in = 2'b00;
    logic       reg_wr = 1'b0, reg_addr = 1'b0;
    logic [1:0] reg_wbits = 2'b00;
    logic [7:0] reg_rdata;
    logic       core_rst_o, ext_rst_o, wake_apply_o, pll_mode_o, busy_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rst_seq_ctrl #(.CNT_CYCLES(16)) u0 (.*);

    typedef struct packed {
        logic [1:0] op;      // 0 sys, 1 ext, 2 scan
        logic       lvl;
        logic       wake;
        logic       pll;
        logic [1:0] boot;
        logic [5:0] exp_core;
        logic [5:0] exp_ext;
        logic [7:0] exp_stat;
        logic       exp_wk;
        logic       exp_pl;
        logic [7:0] exp_mid;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 1'b0, 1'b1, 1'b1, 2'd2, 6'd22, 6'd22, 8'h51, 1'b1, 1'b1, 8'h01},
        '{2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 6'd0,  6'd16, 8'h53, 1'b1, 1'b1, 8'h02},
        '{2'd2, 1'b1, 1'b0, 1'b0, 2'd3, 6'd20, 6'd3,  8'h63, 1'b0, 1'b0, 8'h00},
        '{2'd2, 1'b0, 1'b1, 1'b1, 2'd0, 6'd20, 6'd0,  8'h13, 1'b1, 1'b1, 8'h00},
        '{2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 6'd22, 6'd22, 8'h21, 1'b0, 1'b0, 8'h01},
        '{2'd1, 1'b0, 1'b1, 1'b1, 2'd2, 6'd0,  6'd16, 8'h23, 1'b0, 1'b0, 8'h02}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
        reg_addr = 1'b0;
    endtask

    task automatic wr_stat(input logic [1:0] b);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wbits = b;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    // op 3 writes both control bits; inj_kind 1: ctrl write, 2: scan preempt, 3: change cfg inputs
    task automatic run_seq(input int op, input logic lvl, input int inj_i, input int inj_kind,
                           output int nc, output int ne, output logic [7:0] mid,
                           output int end_i, output int last_hi);
        int drop_i;
        nc = 0; ne = 0; mid = 8'h00; end_i = -1; last_hi = -1;
        drop_i = (op == 2) ? 2 : -1;
        @(negedge clk);
        case (op)
            0: begin reg_wr = 1'b1; reg_addr = 1'b0; reg_wbits = 2'b01; end
            1: begin reg_wr = 1'b1; reg_addr = 1'b0; reg_wbits = 2'b10; end
            3: begin reg_wr = 1'b1; reg_addr = 1'b0; reg_wbits = 2'b11; end
            default: begin scan_rst_req = 1'b1; scan_ext_lvl = lvl; end
        endcase
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (core_rst_o) nc++;
            if (ext_rst_o) ne++;
            if (core_rst_o || ext_rst_o) last_hi = i;
            if (i == 5) mid = reg_rdata;
            reg_wr = 1'b0;
            if (!busy_o) begin end_i = i; break; end
            if (i == drop_i) scan_rst_req = 1'b0;
            if (i == inj_i) begin
                case (inj_kind)
                    1: begin reg_wr = 1'b1; reg_wbits = 2'b01; end
                    2: begin scan_rst_req = 1'b1; scan_ext_lvl = 1'b0; drop_i = i + 2; end
                    3: begin wake_cfg_in = 1'b0; boot_cfg_in = 2'd3; end
                    default: ;
                endcase
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int nc, ne, ei, lh;
        logic [7:0] mid;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!core_rst_o && !ext_rst_o && !busy_o, "R1 outputs", {core_rst_o, ext_rst_o, busy_o}, 0);
        chk(!wake_apply_o && !pll_mode_o, "R1 latched", {wake_apply_o, pll_mode_o}, 0);
        rd(1'b0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        rd(1'b1, v); chk(v == 8'h00, "R1 status", v, 0);

        // table walk: R2 R4 R5 R6 R7 R10
        for (int k = 0; k < 6; k++) begin
            wake_cfg_in = VECS[k].wake;
            pll_mode_in = VECS[k].pll;
            boot_cfg_in = VECS[k].boot;
            run_seq(int'(VECS[k].op), VECS[k].lvl, -1, 0, nc, ne, mid, ei, lh);
            chk(nc == int'(VECS[k].exp_core), "R2/R4/R5 core cycles", nc, VECS[k].exp_core);
            chk(ne == int'(VECS[k].exp_ext), "R2/R4/R5 ext cycles", ne, VECS[k].exp_ext);
            rd(1'b1, v); chk(v == VECS[k].exp_stat, "R2/R4/R5 status", v, VECS[k].exp_stat);
            chk(wake_apply_o == VECS[k].exp_wk && pll_mode_o == VECS[k].exp_pl, "R6 latched",
                {wake_apply_o, pll_mode_o}, {VECS[k].exp_wk, VECS[k].exp_pl});
            chk(mid == VECS[k].exp_mid, "R7 ctrl during", mid, VECS[k].exp_mid);
            rd(1'b0, v); chk(v == 8'h00, "R7 ctrl after", v, 0);
            chk(ei == lh + 2, "R10 busy tail", ei, lh + 2);
        end

        // R9 write-one-to-clear
        wr_stat(2'b10);
        rd(1'b1, v); chk(v == 8'h21, "R9 clear ext", v, 8'h21);
        wr_stat(2'b01);
        rd(1'b1, v); chk(v == 8'h20, "R9 clear sys keeps cfg", v, 8'h20);

        // R8 ignored write during external-only reset
        wake_cfg_in = 1'b1; boot_cfg_in = 2'd2;
        run_seq(1, 1'b0, 3, 1, nc, ne, mid, ei, lh);
        chk(nc == 0, "R8 ignored core", nc, 0);
        chk(ne == 16, "R8 ignored ext", ne, 16);
        rd(1'b1, v); chk(v == 8'h22, "R8 ignored status", v, 8'h22);

        // R11 both control bits
        run_seq(3, 1'b0, -1, 0, nc, ne, mid, ei, lh);
        chk(nc == 22, "R11 core cycles", nc, 22);
        chk(mid == 8'h01, "R11 ctrl during", mid, 8'h01);
        rd(1'b1, v); chk(v == 8'h51, "R11 status", v, 8'h51);

        // R3 inputs changed during the 4-cycle hold are not captured
        wr_stat(2'b11);
        wake_cfg_in = 1'b1; boot_cfg_in = 2'd0;
        run_seq(0, 1'b0, 18, 3, nc, ne, mid, ei, lh);
        chk(ne == 22, "R3 ext cycles", ne, 22);
        rd(1'b1, v); chk(v == 8'h11, "R3 status", v, 8'h11);

        // R8 scan preemption of system reset
        wr_stat(2'b11);
        wake_cfg_in = 1'b1; pll_mode_in = 1'b0; boot_cfg_in = 2'd1;
        run_seq(0, 1'b0, 4, 2, nc, ne, mid, ei, lh);
        chk(nc == 24, "R8 preempt core", nc, 24);
        chk(ne == 5, "R8 preempt ext", ne, 5);
        rd(1'b1, v); chk(v == 8'h30, "R8 preempt status", v, 8'h30);
        chk(wake_apply_o && !pll_mode_o, "R6 preempt latched", {wake_apply_o, pll_mode_o}, 2'b10);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule